// File: doc/BRIEF.md
# Servo Command Byte Loader

This block sits between a host microcontroller byte link and the servo work RAM. Every accepted byte is either the head of a new command or one of its operands. A head byte has two halves: the high four bits select the servo operation and the low four bits say how many operand bytes will follow. The block writes the head into a fixed pending-command cell of the RAM. It keeps that cell's low half as a live down-counter that is rewritten with each operand. Operands are stacked downward from a fixed top address. When the last operand lands, the block raises a one-cycle ready strobe that carries the operation code.

Two full head values change where operands go. A direct-write head takes a target address as its first operand, which is stacked, and then writes its second operand straight to that target. A decoder-write head places its single operand in a fixed decoder slot. A head whose low half is zero is a read request. No operand follows it, and the block pulses a read strobe so that the host side can prepare a reply. The RAM is external and has two write ports: one for operand data and one dedicated to the pending-command cell.

Top module: `servo_cmd_loader`

## Requirements
- R1: When the loader is idle (pending count zero) and a valid byte arrives, it is taken as a head. One cycle later cnt_we is high and cnt_wdata holds the head's high nibble, with the low nibble equal to the (clipped) operand count. That port targets RAM cell 0x31.
- R2: For ordinary heads, operand k (counting from 1) is written on the operand port to address 0x31 - k, so the first operand goes to 0x30. The write appears one cycle after acceptance, and par_wdata equals the byte.
- R3: Each accepted operand rewrites the pending cell through cnt_we/cnt_wdata. The high nibble stays the same and the low nibble is one less than before.
- R4: cmd_ready is high for exactly one cycle, one cycle after the final operand is accepted, and cmd_op then equals the head's high nibble. It never coincides with rd_req.
- R5: A declared count above 6 is clipped to 6. cnt_err pulses in the head's output cycle, and no operand address ever goes below 0x2B for ordinary heads.
- R6: A head with low nibble 0 pulses rd_req one cycle later, with cmd_op set to its high nibble and no operand write. The next valid byte is again a head.
- R7: For head 0xA2, the first operand is written to 0x30. The second operand is written to the address given by the first.
- R8: If that second operand targets 0x31, the data write takes priority and cnt_we stays low in that cycle. cmd_ready still pulses.
- R9: For head 0xD1, the single operand is written to address 0x4D and not to the stack.
- R10: A synchronous active-high reset clears the pending count and all strobes and write enables. The first valid byte after reset is a head, even if a command was left unfinished.
- R11: A cycle with in_valid low produces no write and no strobe in the following cycle, and it does not advance the operand sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is presented this cycle |
| in_byte | input | 8 | Byte from the host link |
| par_we | output | 1 | Operand write enable |
| par_addr | output | 8 | Operand write address |
| par_wdata | output | 8 | Operand write data |
| cnt_we | output | 1 | Pending-command cell write enable (cell 0x31) |
| cnt_wdata | output | 8 | Opcode and remaining count |
| cmd_ready | output | 1 | One-cycle command complete strobe |
| rd_req | output | 1 | One-cycle read request strobe |
| cmd_op | output | 4 | Opcode accompanying the strobes |
| cnt_err | output | 1 | Declared count was clipped |

## Verification
The two functions that can fall in the same cycle are the direct-write data store and the pending-counter update: both want cell 0x31 when the direct-write target is that cell. This is provoked directly with the head 0xA2, target 0x31 and a data byte, and randomly by biasing direct-write targets toward 0x31. Correct handling is judged by par_we carrying the data to 0x31 while cnt_we stays low and cmd_ready pulses in the same cycle. A second coincidence is completion of one command and acceptance of the next head on back-to-back bytes. It is judged by cmd_ready for the first command and cnt_we for the new head appearing on consecutive cycles.

// File: rtl/servo_cmd_pkg.sv
package servo_cmd_pkg;
  typedef enum logic [1:0] {
    PK_STACK  = 2'd0,
    PK_WRADDR = 2'd1,
    PK_WRDEC  = 2'd2
  } pkind_t;
endpackage

// File: rtl/servo_cmd_decode.sv
module servo_cmd_decode
  import servo_cmd_pkg::*;
#(
  parameter int          BYTE_W     = 8,
  parameter int          DEPTH      = 6,
  parameter logic [7:0]  OP_WRADDR  = 8'hA2,
  parameter logic [7:0]  OP_WRDEC   = 8'hD1
) (
  input  logic [BYTE_W-1:0]   head,
  output logic [BYTE_W/2-1:0] op,
  output logic [BYTE_W/2-1:0] cnt,
  output logic                err,
  output pkind_t              kind
);
  localparam int NIB = BYTE_W / 2;
  localparam logic [NIB-1:0] CNT_MAX = NIB'(DEPTH);

  always_comb begin
    op  = head[BYTE_W-1:NIB];
    err = head[NIB-1:0] > CNT_MAX;
    cnt = err ? CNT_MAX : head[NIB-1:0];
    if (head == OP_WRADDR)     kind = PK_WRADDR;
    else if (head == OP_WRDEC) kind = PK_WRDEC;
    else                       kind = PK_STACK;
  end
endmodule

// File: rtl/servo_cmd_route.sv
module servo_cmd_route
  import servo_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         NIB      = 4,
  parameter logic [7:0] CMD_ADDR = 8'h31,
  parameter logic [7:0] DEC_ADDR = 8'h4D
) (
  input  pkind_t            kind,
  input  logic [NIB-1:0]    rem,
  input  logic [ADDR_W-1:0] sp,
  input  logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] addr,
  output logic              take_tgt,
  output logic              use_sp,
  output logic              hit_cmd
);
  logic is_second;

  always_comb begin
    is_second = (kind == PK_WRADDR) && (rem == NIB'(1));
    take_tgt  = (kind == PK_WRADDR) && (rem == NIB'(2));
    use_sp    = (kind != PK_WRDEC) && !is_second;
    if (kind == PK_WRDEC)  addr = ADDR_W'(DEC_ADDR);
    else if (is_second)    addr = tgt;
    else                   addr = sp;
    hit_cmd = (addr == ADDR_W'(CMD_ADDR));
  end
endmodule

// File: rtl/servo_cmd_seq.sv
module servo_cmd_seq
  import servo_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         BYTE_W    = 8,
  parameter logic [7:0] STACK_TOP = 8'h30
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [BYTE_W-1:0]       in_byte,
  input  logic [BYTE_W/2-1:0]     d_op,
  input  logic [BYTE_W/2-1:0]     d_cnt,
  input  logic                    d_err,
  input  pkind_t                  d_kind,
  input  logic [ADDR_W-1:0]       r_addr,
  input  logic                    r_take_tgt,
  input  logic                    r_use_sp,
  input  logic                    r_hit_cmd,
  output pkind_t                  kind,
  output logic [BYTE_W/2-1:0]     rem,
  output logic [ADDR_W-1:0]       sp,
  output logic [ADDR_W-1:0]       tgt,
  output logic                    par_we,
  output logic [ADDR_W-1:0]       par_addr,
  output logic [BYTE_W-1:0]       par_wdata,
  output logic                    cnt_we,
  output logic [BYTE_W-1:0]       cnt_wdata,
  output logic                    cmd_ready,
  output logic                    rd_req,
  output logic [BYTE_W/2-1:0]     cmd_op,
  output logic                    cnt_err
);
  localparam int NIB = BYTE_W / 2;
  logic [NIB-1:0] op;
  logic [NIB-1:0] rem_nx;

  assign rem_nx = rem - NIB'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem       <= '0;
      op        <= '0;
      kind      <= PK_STACK;
      sp        <= ADDR_W'(STACK_TOP);
      tgt       <= '0;
      par_we    <= 1'b0;
      par_addr  <= '0;
      par_wdata <= '0;
      cnt_we    <= 1'b0;
      cnt_wdata <= '0;
      cmd_ready <= 1'b0;
      rd_req    <= 1'b0;
      cmd_op    <= '0;
      cnt_err   <= 1'b0;
    end else begin
      par_we    <= 1'b0;
      cnt_we    <= 1'b0;
      cmd_ready <= 1'b0;
      rd_req    <= 1'b0;
      cnt_err   <= 1'b0;
      if (in_valid) begin
        if (rem == '0) begin
          op        <= d_op;
          rem       <= d_cnt;
          kind      <= d_kind;
          sp        <= ADDR_W'(STACK_TOP);
          cnt_we    <= 1'b1;
          cnt_wdata <= {d_op, d_cnt};
          rd_req    <= (d_cnt == '0);
          cnt_err   <= d_err;
          cmd_op    <= d_op;
        end else begin
          rem       <= rem_nx;
          par_we    <= 1'b1;
          par_addr  <= r_addr;
          par_wdata <= in_byte;
          cnt_we    <= !r_hit_cmd;
          cnt_wdata <= {op, rem_nx};
          cmd_ready <= (rem_nx == '0);
          cmd_op    <= op;
          if (r_use_sp)   sp  <= sp - ADDR_W'(1);
          if (r_take_tgt) tgt <= in_byte[ADDR_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/servo_cmd_loader.sv
module servo_cmd_loader
  import servo_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         BYTE_W    = 8,
  parameter int         DEPTH     = 6,
  parameter logic [7:0] CMD_ADDR  = 8'h31,
  parameter logic [7:0] STACK_TOP = 8'h30,
  parameter logic [7:0] DEC_ADDR  = 8'h4D,
  parameter logic [7:0] OP_WRADDR = 8'hA2,
  parameter logic [7:0] OP_WRDEC  = 8'hD1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              par_we,
  output logic [7:0]        par_addr,
  output logic [7:0]        par_wdata,
  output logic              cnt_we,
  output logic [7:0]        cnt_wdata,
  output logic              cmd_ready,
  output logic              rd_req,
  output logic [3:0]        cmd_op,
  output logic              cnt_err
);
  localparam int NIB = BYTE_W / 2;

  logic [NIB-1:0]    d_op, d_cnt, rem;
  logic              d_err;
  pkind_t            d_kind, kind;
  logic [ADDR_W-1:0] sp, tgt, r_addr;
  logic              r_take_tgt, r_use_sp, r_hit_cmd;

  servo_cmd_decode #(
    .BYTE_W(BYTE_W), .DEPTH(DEPTH),
    .OP_WRADDR(OP_WRADDR), .OP_WRDEC(OP_WRDEC)
  ) u_dec (
    .head(in_byte), .op(d_op), .cnt(d_cnt), .err(d_err), .kind(d_kind)
  );

  servo_cmd_route #(
    .ADDR_W(ADDR_W), .NIB(NIB), .CMD_ADDR(CMD_ADDR), .DEC_ADDR(DEC_ADDR)
  ) u_route (
    .kind(kind), .rem(rem), .sp(sp), .tgt(tgt), .addr(r_addr),
    .take_tgt(r_take_tgt), .use_sp(r_use_sp), .hit_cmd(r_hit_cmd)
  );

  servo_cmd_seq #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .STACK_TOP(STACK_TOP)
  ) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .d_op(d_op), .d_cnt(d_cnt), .d_err(d_err), .d_kind(d_kind),
    .r_addr(r_addr), .r_take_tgt(r_take_tgt), .r_use_sp(r_use_sp),
    .r_hit_cmd(r_hit_cmd),
    .kind(kind), .rem(rem), .sp(sp), .tgt(tgt),
    .par_we(par_we), .par_addr(par_addr), .par_wdata(par_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmd_ready(cmd_ready),
    .rd_req(rd_req), .cmd_op(cmd_op), .cnt_err(cnt_err)
  );
endmodule

// File: rtl/servo_cmd_loader_chk.sv
module servo_cmd_loader_chk #(
  parameter int         DEPTH    = 6,
  parameter logic [7:0] CMD_ADDR = 8'h31
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       par_we,
  input logic [7:0] par_addr,
  input logic       cnt_we,
  input logic [7:0] cnt_wdata,
  input logic       cmd_ready,
  input logic       rd_req,
  input logic       cnt_err
);
  localparam logic [3:0] CMAX = 4'(DEPTH);

  AST_CNT_CLIP: assert property (@(posedge clk) disable iff (rst)
    cnt_we |-> cnt_wdata[3:0] <= CMAX); // R5
  AST_ERR_CLIP: assert property (@(posedge clk) disable iff (rst)
    cnt_err |-> (cnt_we && cnt_wdata[3:0] == CMAX)); // R5
  AST_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (cnt_we && cnt_wdata[3:0] == 4'd0 && !par_we)); // R6
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |=> !cmd_ready); // R4
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(cmd_ready && rd_req)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!par_we && !cnt_we && !cmd_ready && !rd_req)); // R11
  AST_SAME_CELL: assert property (@(posedge clk) disable iff (rst)
    (par_we && cnt_we) |-> par_addr != CMD_ADDR); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!par_we && !cnt_we && !cmd_ready && !rd_req && !cnt_err)); // R10
endmodule

bind servo_cmd_loader servo_cmd_loader_chk #(.DEPTH(DEPTH), .CMD_ADDR(CMD_ADDR)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .par_we(par_we),
  .par_addr(par_addr), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .cmd_ready(cmd_ready), .rd_req(rd_req), .cnt_err(cnt_err)
);

// File: tb/sim_servo_cmd_loader.sv
module sim_servo_cmd_loader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       par_we, cnt_we, cmd_ready, rd_req, cnt_err;
  logic [7:0] par_addr, par_wdata, cnt_wdata;
  logic [3:0] cmd_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  servo_cmd_loader u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .par_we(par_we), .par_addr(par_addr), .par_wdata(par_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmd_ready(cmd_ready),
    .rd_req(rd_req), .cmd_op(cmd_op), .cnt_err(cnt_err)
  );

  // reference model state
  int         m_rem, m_kind, m_idx;
  logic [3:0] m_op;
  logic [7:0] m_sp, m_tgt;
  logic       e_par_we, e_cnt_we, e_rdy, e_rd, e_err;
  logic [7:0] e_par_addr, e_par_wdata, e_cnt_wdata;
  logic [3:0] e_op;

  function automatic logic [7:0] head_count(input logic [7:0] b);
    return (b[3:0] > 4'd6) ? 8'd6 : {4'd0, b[3:0]};
  endfunction

  task automatic model_reset();
    m_rem = 0; m_kind = 0; m_idx = 0; m_op = 0; m_sp = 8'h30; m_tgt = 0;
    e_par_we = 0; e_cnt_we = 0; e_rdy = 0; e_rd = 0; e_err = 0;
  endtask

  task automatic model_byte(input logic v, input logic [7:0] b);
    logic [7:0] a;
    e_par_we = 0; e_cnt_we = 0; e_rdy = 0; e_rd = 0; e_err = 0;
    if (!v) return;
    if (m_rem == 0) begin
      m_op = b[7:4];
      m_rem = int'(head_count(b));
      e_err = b[3:0] > 4'd6;
      e_cnt_we = 1;
      e_cnt_wdata = {b[7:4], head_count(b)[3:0]};
      e_rd = (m_rem == 0);
      e_op = b[7:4];
      m_kind = (b == 8'hA2) ? 1 : (b == 8'hD1) ? 2 : 0;
      m_sp = 8'h30;
      m_idx = 0;
    end else begin
      m_idx++;
      if (m_kind == 2) a = 8'h4D;
      else if (m_kind == 1 && m_idx == 2) a = m_tgt;
      else begin a = m_sp; m_sp = m_sp - 8'd1; end
      if (m_kind == 1 && m_idx == 1) m_tgt = b;
      m_rem--;
      e_par_we = 1; e_par_addr = a; e_par_wdata = b;
      e_cnt_we = (a != 8'h31);
      e_cnt_wdata = {m_op, 4'(m_rem)};
      e_rdy = (m_rem == 0);
      e_op = m_op;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(par_we == e_par_we, tag, "par_we R2", 8'(par_we), 8'(e_par_we));
    if (e_par_we) begin
      chk(par_addr == e_par_addr, tag, "par_addr R2", par_addr, e_par_addr);
      chk(par_wdata == e_par_wdata, tag, "par_wdata R2", par_wdata, e_par_wdata);
    end
    chk(cnt_we == e_cnt_we, tag, "cnt_we R3", 8'(cnt_we), 8'(e_cnt_we));
    if (e_cnt_we)
      chk(cnt_wdata == e_cnt_wdata, tag, "cnt_wdata R1", cnt_wdata, e_cnt_wdata);
    chk(cmd_ready == e_rdy, tag, "cmd_ready R4", 8'(cmd_ready), 8'(e_rdy));
    chk(rd_req == e_rd, tag, "rd_req R6", 8'(rd_req), 8'(e_rd));
    chk(cnt_err == e_err, tag, "cnt_err R5", 8'(cnt_err), 8'(e_err));
    if (e_rdy || e_rd)
      chk(cmd_op == e_op, tag, "cmd_op R4", 8'(cmd_op), 8'(e_op));
  endtask

  task automatic step(input logic v, input logic [7:0] b, input string tag);
    in_valid = v; in_byte = b;
    model_byte(v, b);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0;
    @(negedge clk); @(negedge clk);
    model_reset();
    compare("R10 reset");
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] b;
    seed = 32'd7;
    void'($urandom(seed));
    @(negedge clk);
    do_reset();

    step(1, 8'h50, "R6 read head");
    step(1, 8'h23, "R1 head");
    step(1, 8'h11, "R2 op1");
    step(1, 8'h22, "R3 op2");
    step(1, 8'h33, "R4 last");
    step(1, 8'h7F, "R5 clipped head");
    for (int i = 0; i < 6; i++) step(1, 8'(8'h90 + i), "R5 operand");
    step(1, 8'h40, "R5 next byte is head");
    step(1, 8'hA2, "R7 head");
    step(1, 8'h40, "R7 address");
    step(1, 8'h5A, "R7 data");
    step(1, 8'hA2, "R8 head");
    step(1, 8'h31, "R8 address");
    step(1, 8'h77, "R8 data to pending cell");
    step(1, 8'hD1, "R9 head");
    step(1, 8'h3C, "R9 pair");
    step(1, 8'h12, "R11 head");
    step(0, 8'hEE, "R11 idle");
    step(0, 8'hEE, "R11 idle");
    step(1, 8'h01, "R11 op1");
    step(0, 8'h55, "R11 idle");
    step(1, 8'h02, "R11 op2");
    step(1, 8'h13, "R10 head");
    step(1, 8'hAB, "R10 op1");
    do_reset();
    step(1, 8'h20, "R10 first after reset");
    step(1, 8'hC0, "R10 read");

    for (int n = 0; n < 4000; n++) begin
      logic v;
      v = ($urandom % 4) != 0;
      if (m_rem == 0) begin
        case ($urandom % 5)
          0: b = 8'hA2;
          1: b = 8'hD1;
          2: b = {4'($urandom), 4'd0};
          default: b = 8'($urandom);
        endcase
      end else if (m_kind == 1 && m_idx == 0 && ($urandom % 3) == 0) begin
        b = 8'h31;
      end else begin
        b = 8'($urandom);
      end
      step(v, b, "R1 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule